// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Scanner

This block produces the time-multiplexed drive pattern for a segment LCD panel of 51 segment lines and up to 4 common (backplane) lines. It takes a display bit array (one bit per segment per common) and a slow scan clock. Every pin gets a 2-bit level-select code that an analog output stage turns into one of four drive voltages. The polarity of each frame half is reversed, so the average voltage across every pixel is zero.

A 2-bit duty setting picks one of four drive schemes. Static drive uses one common. Half duty uses two commons with a two-level (1/2) bias. Third and quarter duty use three or four commons with 1/3 bias. A blank flag turns the panel off and freezes the scan. A write port clears or sets this flag. A synchronisation input resets the scan position so that several devices can be locked together, and it also sets the blank flag. A standby input blanks the panel and freezes the scan until it is released.

Top module: `lcd_mux_scanner`

## Requirements
- R1: `drive_mode` sets the number of scanned commons: 00 gives 1, 01 gives 2, 10 gives 3 and 11 gives 4. A frame is one positive half and then one negative half. Each half visits the commons in ascending order, COM0 first. While the panel is not blank, exactly one common is selected at any time, and it is the one being scanned.
- R2: Each common slot lasts 1515, 385, 80 or 56 clocks for modes 00, 01, 10 and 11. This gives frame periods of 3030, 1540, 480 and 448 clocks.
- R3: Level codes are 00 = VDD, 01 = V1, 10 = V2 and 11 = V3. A selected common is at VDD (00) in the positive half and at V3 (11) in the negative half.
- R4: In modes 10 and 11 (1/3 bias), an unselected common is at V2 in the positive half and at V1 in the negative half. An on segment is at V3 or VDD, and an off segment is at V1 or V2, in the positive and negative half respectively.
- R5: In modes 00 and 01 (two-level bias), an unselected common is at V1 in both halves. An on segment takes the extreme level opposite the selected common. An off segment takes the same level as the selected common.
- R6: Commons that the current mode does not scan are never selected. They sit at that mode's unselected-common level.
- R7: Segment output n carries bit `seg_bits[c*51+n]`, where c is the common being scanned.
- R8: While the blank flag is set, or `standby` or `sync` is high, every common and segment output is 00.
- R9: While `standby` is high, the scan position does not move. After `standby` is released, scanning resumes from the same slot.
- R10: `sync` high resets the scan to the first slot of the positive half and sets the blank flag. When `sync` and `blank_wr` are high in the same cycle, `sync` wins. A `blank_wr` pulse with `blank_val` = 0 then starts scanning from that first slot.
- R11: After reset, the blank flag is set and the scan position is the first slot of the positive half.
- R12: A change of `drive_mode` restarts the scan at the first slot of the positive half, in the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_mode | input | 2 | Duty / bias selection (R1) |
| blank_wr | input | 1 | Load strobe for the blank flag |
| blank_val | input | 1 | New blank flag value (1 = panel off) |
| sync | input | 1 | Scan reset for multi-device locking |
| standby | input | 1 | Blank the panel and freeze the scan |
| seg_bits | input | 204 | Display bits, index c*51+n |
| com_lvl | output | 8 | Level codes, 2 bits per common, COM0 in bits 1:0 |
| seg_lvl | output | 102 | Level codes, 2 bits per segment, segment 0 in bits 1:0 |

## Verification
The assertions check these properties on every cycle:
- Only the scanned common is selected, and it is one that the current mode scans.
- The slot counter stays below the slot length for the current mode.
- `sync` and `standby` force all outputs to VDD.
- `sync` and a mode change take the scan back to its start.
- Standby freezes the scan position.

The bench scenarios cover what needs expected values over time:
- The exact order of commons and level codes across a full frame in each of the four modes.
- The measured frame periods.
- The segment data routed from the correct bit-array column.
- Resuming at the same slot after standby.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    typedef enum logic [1:0] {
        DUTY_STATIC  = 2'b00,
        DUTY_HALF    = 2'b01,
        DUTY_THIRD   = 2'b10,
        DUTY_QUARTER = 2'b11
    } duty_e;

    typedef enum logic [1:0] {
        LVL_VDD = 2'b00,
        LVL_V1  = 2'b01,
        LVL_V2  = 2'b10,
        LVL_V3  = 2'b11
    } lvl_e;

    localparam int COM_MAX   = 4;
    localparam int COM_IDX_W = $clog2(COM_MAX);

    // Index of the highest scanned common equals the duty code.
    function automatic logic [COM_IDX_W-1:0] last_com(input duty_e d);
        return COM_IDX_W'(d);
    endfunction

    function automatic logic third_bias(input duty_e d);
        return d[1];
    endfunction

    function automatic lvl_e com_level(input logic sel, input logic pol, input logic third);
        if (sel)        return pol ? LVL_V3 : LVL_VDD;
        else if (third) return pol ? LVL_V1 : LVL_V2;
        else            return LVL_V1;
    endfunction

    function automatic lvl_e seg_level(input logic on, input logic pol, input logic third);
        if (on)         return pol ? LVL_VDD : LVL_V3;
        else if (third) return pol ? LVL_V2 : LVL_V1;
        else            return pol ? LVL_V3 : LVL_VDD;
    endfunction

endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
    import lcd_scan_pkg::*;
#(
    parameter int SLOT_STATIC  = 1515,
    parameter int SLOT_HALF    = 385,
    parameter int SLOT_THIRD   = 80,
    parameter int SLOT_QUARTER = 56,
    parameter int CNT_W        = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode_i,
    input  logic                 sync_i,
    input  logic                 standby_i,
    input  logic                 blank_wr_i,
    input  logic                 blank_val_i,
    output logic [CNT_W-1:0]     cnt_o,
    output logic [COM_IDX_W-1:0] com_o,
    output logic                 pol_o,
    output logic                 blank_o,
    output logic [1:0]           mode_o
);

    typedef struct packed {
        logic [CNT_W-1:0]     cnt;
        logic [COM_IDX_W-1:0] com;
        logic                 pol;
        logic                 blank;
        duty_e                mode;
    } scan_state_t;

    scan_state_t st_d, st_q;
    logic [CNT_W-1:0] slot_last;

    always_comb begin
        case (st_q.mode)
            DUTY_STATIC:  slot_last = CNT_W'(SLOT_STATIC - 1);
            DUTY_HALF:    slot_last = CNT_W'(SLOT_HALF - 1);
            DUTY_THIRD:   slot_last = CNT_W'(SLOT_THIRD - 1);
            default:      slot_last = CNT_W'(SLOT_QUARTER - 1);
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.mode = duty_e'(mode_i);
        if (blank_wr_i) st_d.blank = blank_val_i;
        if (sync_i) begin
            st_d.cnt   = '0;
            st_d.com   = '0;
            st_d.pol   = 1'b0;
            st_d.blank = 1'b1;
        end else if (mode_i != st_q.mode) begin
            st_d.cnt = '0;
            st_d.com = '0;
            st_d.pol = 1'b0;
        end else if (!(standby_i || st_q.blank)) begin
            if (st_q.cnt == slot_last) begin
                st_d.cnt = '0;
                if (st_q.com == last_com(st_q.mode)) begin
                    st_d.com = '0;
                    st_d.pol = ~st_q.pol;
                end else begin
                    st_d.com = st_q.com + 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.com   <= '0;
            st_q.pol   <= 1'b0;
            st_q.blank <= 1'b1;
            st_q.mode  <= DUTY_STATIC;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o   = st_q.cnt;
    assign com_o   = st_q.com;
    assign pol_o   = st_q.pol;
    assign blank_o = st_q.blank;
    assign mode_o  = st_q.mode;

endmodule

// File: rtl/lcd_com_drive.sv
module lcd_com_drive
    import lcd_scan_pkg::*;
(
    input  logic [COM_IDX_W-1:0] com_idx,
    input  logic                 pol,
    input  logic [1:0]           mode,
    input  logic                 blank,
    output logic [2*COM_MAX-1:0] com_lvl
);

    for (genvar c = 0; c < COM_MAX; c++) begin : g_com
        logic active;
        logic sel;
        lvl_e lvl;
        always_comb begin
            active = (COM_IDX_W'(c) <= last_com(duty_e'(mode)));
            sel    = active && (com_idx == COM_IDX_W'(c));
            lvl    = blank ? LVL_VDD : com_level(sel, pol, third_bias(duty_e'(mode)));
        end
        assign com_lvl[2*c +: 2] = lvl;
    end

endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive
    import lcd_scan_pkg::*;
#(
    parameter int NUM_SEG = 51
) (
    input  logic [NUM_SEG*COM_MAX-1:0] seg_bits,
    input  logic [COM_IDX_W-1:0]       com_idx,
    input  logic                       pol,
    input  logic [1:0]                 mode,
    input  logic                       blank,
    output logic [2*NUM_SEG-1:0]       seg_lvl
);

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        logic [COM_MAX-1:0] column;
        lvl_e lvl;
        for (genvar c = 0; c < COM_MAX; c++) begin : g_col
            assign column[c] = seg_bits[c*NUM_SEG + s];
        end
        always_comb begin
            lvl = blank ? LVL_VDD
                        : seg_level(column[com_idx], pol, third_bias(duty_e'(mode)));
        end
        assign seg_lvl[2*s +: 2] = lvl;
    end

endmodule

// File: rtl/lcd_mux_scanner.sv
module lcd_mux_scanner
    import lcd_scan_pkg::*;
#(
    parameter int NUM_SEG      = 51,
    parameter int SLOT_STATIC  = 1515,
    parameter int SLOT_HALF    = 385,
    parameter int SLOT_THIRD   = 80,
    parameter int SLOT_QUARTER = 56
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 drive_mode,
    input  logic                       blank_wr,
    input  logic                       blank_val,
    input  logic                       sync,
    input  logic                       standby,
    input  logic [NUM_SEG*COM_MAX-1:0] seg_bits,
    output logic [2*COM_MAX-1:0]       com_lvl,
    output logic [2*NUM_SEG-1:0]       seg_lvl
);

    localparam int SLOT_MAX_A = (SLOT_STATIC > SLOT_HALF) ? SLOT_STATIC : SLOT_HALF;
    localparam int SLOT_MAX_B = (SLOT_THIRD > SLOT_QUARTER) ? SLOT_THIRD : SLOT_QUARTER;
    localparam int SLOT_MAX   = (SLOT_MAX_A > SLOT_MAX_B) ? SLOT_MAX_A : SLOT_MAX_B;
    localparam int CNT_W      = $clog2(SLOT_MAX + 1);

    logic [CNT_W-1:0]     scan_cnt;
    logic [COM_IDX_W-1:0] scan_com;
    logic                 scan_pol;
    logic                 blank_q;
    logic [1:0]           cur_mode;
    logic                 blank_out;

    lcd_scan_timer #(
        .SLOT_STATIC (SLOT_STATIC),
        .SLOT_HALF   (SLOT_HALF),
        .SLOT_THIRD  (SLOT_THIRD),
        .SLOT_QUARTER(SLOT_QUARTER),
        .CNT_W       (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (drive_mode),
        .sync_i     (sync),
        .standby_i  (standby),
        .blank_wr_i (blank_wr),
        .blank_val_i(blank_val),
        .cnt_o      (scan_cnt),
        .com_o      (scan_com),
        .pol_o      (scan_pol),
        .blank_o    (blank_q),
        .mode_o     (cur_mode)
    );

    assign blank_out = blank_q | standby | sync;

    lcd_com_drive u_com (
        .com_idx(scan_com),
        .pol    (scan_pol),
        .mode   (cur_mode),
        .blank  (blank_out),
        .com_lvl(com_lvl)
    );

    lcd_seg_drive #(.NUM_SEG(NUM_SEG)) u_seg (
        .seg_bits(seg_bits),
        .com_idx (scan_com),
        .pol     (scan_pol),
        .mode    (cur_mode),
        .blank   (blank_out),
        .seg_lvl (seg_lvl)
    );

endmodule

// File: rtl/lcd_mux_scanner_chk.sv
module lcd_mux_scanner_chk
    import lcd_scan_pkg::*;
#(
    parameter int NUM_SEG      = 51,
    parameter int CNT_W        = 11,
    parameter int SLOT_STATIC  = 1515,
    parameter int SLOT_HALF    = 385,
    parameter int SLOT_THIRD   = 80,
    parameter int SLOT_QUARTER = 56
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sync,
    input logic                 standby,
    input logic [1:0]           drive_mode,
    input logic [2*COM_MAX-1:0] com_lvl,
    input logic [2*NUM_SEG-1:0] seg_lvl,
    input logic [CNT_W-1:0]     scan_cnt,
    input logic [COM_IDX_W-1:0] scan_com,
    input logic                 scan_pol,
    input logic [1:0]           cur_mode,
    input logic                 blank_q
);

    logic [COM_MAX-1:0] sel_mask;
    logic [COM_MAX-1:0] act_mask;
    logic [CNT_W-1:0]   slot_lim;
    logic               live;

    always_comb begin
        for (int c = 0; c < COM_MAX; c++) begin
            sel_mask[c] = (com_lvl[2*c +: 2] == LVL_VDD) || (com_lvl[2*c +: 2] == LVL_V3);
            act_mask[c] = (COM_IDX_W'(c) <= cur_mode);
        end
        case (cur_mode)
            2'b00:   slot_lim = CNT_W'(SLOT_STATIC);
            2'b01:   slot_lim = CNT_W'(SLOT_HALF);
            2'b10:   slot_lim = CNT_W'(SLOT_THIRD);
            default: slot_lim = CNT_W'(SLOT_QUARTER);
        endcase
        live = !standby && !sync && !blank_q;
    end

    // R1
    one_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (sel_mask == (COM_MAX'(1) << scan_com)));

    // R6
    unused_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> ((sel_mask & ~act_mask) == '0));

    // R2
    slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_cnt < slot_lim);

    // R8
    blank_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (standby || sync) |-> (com_lvl == '0 && seg_lvl == '0));

    // R10
    sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (blank_q && scan_cnt == '0 && scan_com == '0 && !scan_pol));

    // R9
    standby_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && !sync && drive_mode == cur_mode)
            |=> ($stable(scan_cnt) && $stable(scan_com) && $stable(scan_pol)));

    // R12
    mode_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_mode != cur_mode) |=> (scan_cnt == '0 && scan_com == '0 && !scan_pol));

endmodule

bind lcd_mux_scanner lcd_mux_scanner_chk #(
    .NUM_SEG     (NUM_SEG),
    .CNT_W       (CNT_W),
    .SLOT_STATIC (SLOT_STATIC),
    .SLOT_HALF   (SLOT_HALF),
    .SLOT_THIRD  (SLOT_THIRD),
    .SLOT_QUARTER(SLOT_QUARTER)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync      (sync),
    .standby   (standby),
    .drive_mode(drive_mode),
    .com_lvl   (com_lvl),
    .seg_lvl   (seg_lvl),
    .scan_cnt  (scan_cnt),
    .scan_com  (scan_com),
    .scan_pol  (scan_pol),
    .cur_mode  (cur_mode),
    .blank_q   (blank_q)
);

// File: tb/lcd_mux_scanner_test.sv
module lcd_mux_scanner_test;

    localparam int NSEG = 51;

    typedef struct packed {
        logic [1:0] mode;
        int         ncom;
        int         slot;
        int         frame;
    } vec_t;

    // Per R1/R2: mode code, scanned commons, slot length, frame period
    localparam vec_t VECS [4] = '{
        '{2'b00, 1, 1515, 3030},
        '{2'b01, 2, 385,  1540},
        '{2'b10, 3, 80,   480},
        '{2'b11, 4, 56,   448}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [1:0]        drive_mode;
    logic              blank_wr, blank_val, sync, standby;
    logic [NSEG*4-1:0] seg_bits;
    logic [7:0]        com_lvl;
    logic [2*NSEG-1:0] seg_lvl;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    lcd_mux_scanner uut (
        .clk(clk), .rst_n(rst_n), .drive_mode(drive_mode),
        .blank_wr(blank_wr), .blank_val(blank_val), .sync(sync),
        .standby(standby), .seg_bits(seg_bits),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R3/R4/R5/R6: expected common codes
    function automatic logic [7:0] exp_com(input int k, input bit p, input logic [1:0] m);
        logic [7:0] r;
        for (int c = 0; c < 4; c++) begin
            logic [1:0] unsel;
            unsel = m[1] ? (p ? 2'b01 : 2'b10) : 2'b01;
            if (c <= int'(m) && c == k) r[2*c +: 2] = p ? 2'b11 : 2'b00;
            else                        r[2*c +: 2] = unsel;
        end
        return r;
    endfunction

    // R4/R5/R7: expected segment codes
    function automatic logic [2*NSEG-1:0] exp_seg(input int k, input bit p, input logic [1:0] m);
        logic [2*NSEG-1:0] r;
        for (int s = 0; s < NSEG; s++) begin
            if (seg_bits[k*NSEG + s]) r[2*s +: 2] = p ? 2'b00 : 2'b11;
            else if (m[1])            r[2*s +: 2] = p ? 2'b10 : 2'b01;
            else                      r[2*s +: 2] = p ? 2'b11 : 2'b00;
        end
        return r;
    endfunction

    // sync pulse, then clear the blank flag; returns at the first scanning cycle
    task automatic start_scan(input logic [1:0] m);
        @(negedge clk);
        drive_mode = m;
        sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
        blank_wr = 1'b1;
        blank_val = 1'b0;
        @(negedge clk);
        blank_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive_mode = 2'b00;
        blank_wr = 1'b0;
        blank_val = 1'b0;
        sync = 1'b0;
        standby = 1'b0;
        for (int c = 0; c < 4; c++)
            for (int s = 0; s < NSEG; s++)
                seg_bits[c*NSEG + s] = (((s * 5) + (c * 3)) % 7) < 3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: blank after reset, and it stays blank without a write
        @(negedge clk);
        chk("R11 reset com", 128'(com_lvl), 128'(0));
        repeat (600) @(negedge clk);
        chk("R11 held blank seg", 128'(seg_lvl), 128'(0));
        // R11: clearing the flag starts at the first positive-half slot
        blank_wr = 1'b1;
        blank_val = 1'b0;
        @(negedge clk);
        blank_wr = 1'b0;
        chk("R11 first slot com", 128'(com_lvl), 128'(exp_com(0, 1'b0, 2'b00)));

        // Table walk: R1 R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 4; i++) begin
            vec_t v;
            int   cnt;
            v = VECS[i];
            start_scan(v.mode);
            for (int k = 0; k < 2 * v.ncom; k++) begin
                repeat ((k == 0) ? v.slot / 2 : v.slot) @(negedge clk);
                chk($sformatf("R1/R3 mode %0d slot %0d com", v.mode, k), 128'(com_lvl),
                    128'(exp_com(k % v.ncom, (k / v.ncom) == 1, v.mode)));
                chk($sformatf("R7/R4/R5 mode %0d slot %0d seg", v.mode, k), 128'(seg_lvl),
                    128'(exp_seg(k % v.ncom, (k / v.ncom) == 1, v.mode)));
            end
            while (com_lvl[1:0] != 2'b00) @(negedge clk);
            cnt = 0;
            while (com_lvl[1:0] == 2'b00) begin @(negedge clk); cnt++; end
            while (com_lvl[1:0] != 2'b00) begin @(negedge clk); cnt++; end
            chk($sformatf("R2 mode %0d frame", v.mode), 128'(cnt), 128'(v.frame));
        end

        // R9: standby blanks and freezes; scan resumes at the same slot
        begin
            logic [7:0] snap;
            start_scan(2'b11);
            repeat (56 * 2 + 28) @(negedge clk);
            snap = com_lvl;
            chk("R6 quarter slot2 com", 128'(snap), 128'(exp_com(2, 1'b0, 2'b11)));
            standby = 1'b1;
            @(negedge clk);
            chk("R8 standby blank", 128'({com_lvl, seg_lvl}), 128'(0));
            repeat (1000) @(negedge clk);
            standby = 1'b0;
            #1;
            chk("R9 resume same slot", 128'(com_lvl), 128'(snap));
        end

        // R8: blank flag written high
        @(negedge clk);
        blank_wr = 1'b1;
        blank_val = 1'b1;
        @(negedge clk);
        blank_wr = 1'b0;
        chk("R8 blank flag com", 128'(com_lvl), 128'(0));
        chk("R8 blank flag seg", 128'(seg_lvl), 128'(0));

        // R10: sync wins over a simultaneous clear, then restart at slot 0
        start_scan(2'b11);
        repeat (56 * 2 + 28) @(negedge clk);
        sync = 1'b1;
        blank_wr = 1'b1;
        blank_val = 1'b0;
        @(negedge clk);
        sync = 1'b0;
        blank_wr = 1'b0;
        chk("R10 sync sets blank", 128'(com_lvl), 128'(0));
        blank_wr = 1'b1;
        @(negedge clk);
        blank_wr = 1'b0;
        chk("R10 restart com", 128'(com_lvl), 128'(exp_com(0, 1'b0, 2'b11)));
        chk("R10 restart seg", 128'(seg_lvl), 128'(exp_seg(0, 1'b0, 2'b11)));

        // R12: mode change mid-frame restarts; COM3 unused in mode 10 (R6)
        repeat (56 * 3 + 20) @(negedge clk);
        chk("R12 before change com", 128'(com_lvl), 128'(exp_com(3, 1'b0, 2'b11)));
        drive_mode = 2'b10;
        @(negedge clk);
        chk("R12 restart com", 128'(com_lvl), 128'(exp_com(0, 1'b0, 2'b10)));
        chk("R12 restart seg", 128'(seg_lvl), 128'(exp_seg(0, 1'b0, 2'b10)));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule